// File: doc/BRIEF.md
# Amplitude-Binned Timing Slew Corrector

This block corrects a timing measurement for amplitude-dependent walk. Each sample arrives with a channel number, a 12-bit pedestal-subtracted amplitude and a 12-bit time value. For timing channels, the amplitude is compared against that channel's programmable, non-decreasing set of bin upper limits. The signed offset of the matching bin is added to the time value. The sum is saturated to the 12-bit range and presented one clock later. Non-timing channels pass their time value through untouched.

The stage sits after pedestal subtraction and ahead of channel masking. A single-beat write port loads each timing channel's eight limits and eight offsets. After reset every limit is full scale and every offset is zero, so the block is transparent until configured.

Top module: `tac_slew_corrector`

## Requirements
- R1: A timing channel's amplitude falls in bin N when limit[N-1] < amplitude <= limit[N], with bin 0 taking everything from 0 up to and including limit[0].
- R2: When several bins match (equal limits), the lowest-numbered matching bin is used.
- R3: If the amplitude exceeds every programmed limit, the highest bin (bin 7) is used.
- R4: The selected signed offset is added to the time value, and the result is clamped to 0 when negative and to 4095 when above 4095.
- R5: Only channels whose channel-number bit 2 is set (4–7, 12–15, 20–23, 28–31) are corrected; on every other channel out_tac equals in_tac.
- R6: A write with cfg_sel=0 stores cfg_data as the limit, and with cfg_sel=1 stores cfg_data[8:0] as a two's-complement offset, both for (cfg_ch, cfg_bin). A sample accepted in the same cycle as a write still uses the old value, and samples from the next cycle on use the new one.
- R7: Writes addressed to a channel whose bit 2 is clear are ignored and change no timing channel's table.
- R8: Reset clears out_valid, out_ch and out_tac to 0, sets every limit to 4095 and sets every offset to 0, so unprogrammed timing channels are transparent.
- R9: out_valid equals in_valid one cycle earlier. out_tac and out_ch load only on cycles with in_valid high and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | 5 | Channel number of the sample |
| in_adc | input | 12 | Pedestal-subtracted amplitude |
| in_tac | input | 12 | Raw time value |
| cfg_we | input | 1 | Table write strobe |
| cfg_ch | input | 5 | Channel to write |
| cfg_bin | input | 3 | Bin to write |
| cfg_sel | input | 1 | 0 selects limit, 1 selects offset |
| cfg_data | input | 12 | Write data (offset uses low 9 bits, signed) |
| out_valid | output | 1 | Registered sample strobe |
| out_ch | output | 5 | Registered channel number |
| out_tac | output | 12 | Corrected, saturated time value |

## Verification
The hardest conditions to reach are table states that a well-formed configuration never produces. Two cases need such states. One is a channel whose limits all lie below full scale, which exercises the bin-7 fallback. The other is a write to a non-timing channel that aliases onto a timing channel's storage slot. The bench programs both states on purpose and checks at the output that the fallback bin's offset is applied and that the aliased timing channel stays transparent. It also issues a write and a sample on the same clock edge to show that the old table value is used for that sample.

// File: rtl/slew_pkg.sv
package slew_pkg;

  typedef enum logic {
    SEL_LIMIT  = 1'b0,
    SEL_OFFSET = 1'b1
  } cfg_sel_e;

  // Timing channels are the ones with channel-number bit 2 set.
  localparam int TIMING_BIT = 2;

endpackage

// File: rtl/slew_table.sv
module slew_table #(
  parameter int NUM_CH   = 32,
  parameter int NUM_BINS = 8,
  parameter int LIM_W    = 12,
  parameter int OFS_W    = 9,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int BIN_W   = $clog2(NUM_BINS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [CH_W-1:0]           cfg_ch,
  input  logic [BIN_W-1:0]          cfg_bin,
  input  logic                      cfg_sel,
  input  logic [LIM_W-1:0]          cfg_data,
  input  logic [CH_W-1:0]           rd_ch,
  output logic [NUM_BINS*LIM_W-1:0] rd_lim,
  output logic [NUM_BINS*OFS_W-1:0] rd_ofs
);
  import slew_pkg::*;

  // Only half the channels are timing channels: drop bit 2 from the index.
  localparam int NUM_STORE = NUM_CH / 2;
  localparam int IDX_W     = CH_W - 1;
  localparam logic [LIM_W-1:0] LIM_FULL = '1;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_ok;

  assign wr_idx = {cfg_ch[CH_W-1:TIMING_BIT+1], cfg_ch[TIMING_BIT-1:0]};
  assign rd_idx = {rd_ch[CH_W-1:TIMING_BIT+1], rd_ch[TIMING_BIT-1:0]};
  assign wr_ok  = cfg_we && cfg_ch[TIMING_BIT];

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic [LIM_W-1:0] lim_mem [NUM_STORE];
    logic [OFS_W-1:0] ofs_mem [NUM_STORE];
    logic             hit_b;

    assign hit_b = wr_ok && (cfg_bin == BIN_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < NUM_STORE; i++) begin
          lim_mem[i] <= LIM_FULL;
          ofs_mem[i] <= '0;
        end
      end else if (hit_b) begin
        if (cfg_sel == SEL_LIMIT) lim_mem[wr_idx] <= cfg_data;
        else                      ofs_mem[wr_idx] <= cfg_data[OFS_W-1:0];
      end
    end

    assign rd_lim[b*LIM_W +: LIM_W] = lim_mem[rd_idx];
    assign rd_ofs[b*OFS_W +: OFS_W] = ofs_mem[rd_idx];

    AST_IGNORE_LIM: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && !cfg_ch[TIMING_BIT]) |=> lim_mem[$past(wr_idx)] == $past(lim_mem[wr_idx])); // R7
    AST_IGNORE_OFS: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && !cfg_ch[TIMING_BIT]) |=> ofs_mem[$past(wr_idx)] == $past(ofs_mem[wr_idx])); // R7
  end

endmodule

// File: rtl/slew_bin_search.sv
module slew_bin_search #(
  parameter int NUM_BINS = 8,
  parameter int LIM_W    = 12,
  localparam int BIN_W   = $clog2(NUM_BINS)
) (
  input  logic                      rst,
  input  logic [LIM_W-1:0]          adc,
  input  logic [NUM_BINS*LIM_W-1:0] lim_flat,
  output logic [BIN_W-1:0]          bin_sel,
  output logic                      any_hit
);

  logic [LIM_W-1:0]    lim [NUM_BINS];
  logic [NUM_BINS-1:0] le;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_cmp
    assign lim[b] = lim_flat[b*LIM_W +: LIM_W];
    assign le[b]  = (adc <= lim[b]);
  end

  // Lowest matching bin wins; with no match the top bin is used.
  always_comb begin
    bin_sel = BIN_W'(NUM_BINS - 1);
    for (int b = NUM_BINS - 1; b >= 0; b--) begin
      if (le[b]) bin_sel = BIN_W'(b);
    end
  end

  assign any_hit = |le;

  always_comb begin
    if (!rst && any_hit) begin
      AST_BIN_COVERS: assert (adc <= lim[bin_sel]); // R1
      if (bin_sel != '0) begin
        AST_LOWEST_BIN: assert (adc > lim[bin_sel - 1'b1]); // R2
      end
    end
    if (!rst && !any_hit) begin
      AST_FALLBACK_TOP: assert (bin_sel == BIN_W'(NUM_BINS - 1)); // R3
    end
  end

endmodule

// File: rtl/slew_offset_add.sv
module slew_offset_add #(
  parameter int TAC_W = 12,
  parameter int OFS_W = 9,
  localparam int SUM_W = ((TAC_W > OFS_W) ? TAC_W : OFS_W) + 2
) (
  input  logic                    rst,
  input  logic [TAC_W-1:0]        tac,
  input  logic signed [OFS_W-1:0] ofs,
  output logic [TAC_W-1:0]        res
);

  localparam logic signed [SUM_W-1:0] TAC_MAX = SUM_W'((1 << TAC_W) - 1);

  logic signed [SUM_W-1:0] sum;

  assign sum = $signed({{(SUM_W-TAC_W){1'b0}}, tac}) + SUM_W'(ofs);

  always_comb begin
    if (sum < 0)             res = '0;
    else if (sum > TAC_MAX)  res = '1;
    else                     res = sum[TAC_W-1:0];
  end

  always_comb begin
    if (!rst && (ofs >= 0)) begin
      AST_POS_NOT_BELOW: assert (res >= tac); // R4
    end
    if (!rst && (ofs < 0)) begin
      AST_NEG_NOT_ABOVE: assert (res <= tac); // R4
    end
  end

endmodule

// File: rtl/tac_slew_corrector.sv
module tac_slew_corrector #(
  parameter int NUM_CH   = 32,
  parameter int NUM_BINS = 8,
  parameter int ADC_W    = 12,
  parameter int TAC_W    = 12,
  parameter int OFS_W    = 9,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int BIN_W   = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [ADC_W-1:0]  in_adc,
  input  logic [TAC_W-1:0]  in_tac,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [BIN_W-1:0]  cfg_bin,
  input  logic              cfg_sel,
  input  logic [ADC_W-1:0]  cfg_data,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output logic [TAC_W-1:0]  out_tac
);
  import slew_pkg::*;

  logic [NUM_BINS*ADC_W-1:0] row_lim;
  logic [NUM_BINS*OFS_W-1:0] row_ofs;
  logic [BIN_W-1:0]          bin_sel;
  logic                      any_hit;
  logic signed [OFS_W-1:0]   ofs_sel;
  logic [TAC_W-1:0]          tac_adj;
  logic [TAC_W-1:0]          tac_next;

  slew_table #(
    .NUM_CH(NUM_CH), .NUM_BINS(NUM_BINS), .LIM_W(ADC_W), .OFS_W(OFS_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_bin(cfg_bin),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .rd_ch(in_ch), .rd_lim(row_lim), .rd_ofs(row_ofs)
  );

  slew_bin_search #(
    .NUM_BINS(NUM_BINS), .LIM_W(ADC_W)
  ) u_search (
    .rst(rst), .adc(in_adc), .lim_flat(row_lim),
    .bin_sel(bin_sel), .any_hit(any_hit)
  );

  assign ofs_sel = $signed(row_ofs[bin_sel*OFS_W +: OFS_W]);

  slew_offset_add #(
    .TAC_W(TAC_W), .OFS_W(OFS_W)
  ) u_add (
    .rst(rst), .tac(in_tac), .ofs(ofs_sel), .res(tac_adj)
  );

  assign tac_next = in_ch[TIMING_BIT] ? tac_adj : in_tac;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_tac   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch  <= in_ch;
        out_tac <= tac_next;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_tac) && $stable(out_ch))); // R9
  AST_PASS_OTHER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ch[TIMING_BIT]) |=> out_tac == $past(in_tac)); // R5

endmodule

// File: tb/tac_slew_corrector_test.sv
module tac_slew_corrector_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  in_ch;
  logic [11:0] in_adc;
  logic [11:0] in_tac;
  logic        cfg_we;
  logic [4:0]  cfg_ch;
  logic [2:0]  cfg_bin;
  logic        cfg_sel;
  logic [11:0] cfg_data;
  logic        out_valid;
  logic [4:0]  out_ch;
  logic [11:0] out_tac;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tac_slew_corrector uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ch(in_ch), .in_adc(in_adc), .in_tac(in_tac),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_bin(cfg_bin),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_tac(out_tac)
  );

  // {requirement, channel, adc, tac, expected out_tac}
  localparam int NV = 21;
  localparam logic [44:0] VEC [NV] = '{
    {4'd1, 5'd4,  12'd0,    12'd1000, 12'd1131},  // R1 zero in bin 0
    {4'd1, 5'd4,  12'd30,   12'd1000, 12'd1131},  // R1 on limit 0
    {4'd1, 5'd4,  12'd31,   12'd1000, 12'd1078},  // R1 just above
    {4'd1, 5'd4,  12'd60,   12'd1000, 12'd1078},
    {4'd1, 5'd4,  12'd61,   12'd1000, 12'd1045},
    {4'd1, 5'd4,  12'd135,  12'd1000, 12'd1026},
    {4'd1, 5'd4,  12'd136,  12'd1000, 12'd1010},
    {4'd1, 5'd4,  12'd600,  12'd1000, 12'd976},
    {4'd1, 5'd4,  12'd601,  12'd1000, 12'd952},
    {4'd4, 5'd4,  12'd4095, 12'd20,   12'd0},     // R4 clamp low
    {4'd4, 5'd4,  12'd0,    12'd4000, 12'd4095},  // R4 clamp high
    {4'd4, 5'd4,  12'd200,  12'd5,    12'd15},
    {4'd2, 5'd29, 12'd10,   12'd100,  12'd101},   // R2
    {4'd2, 5'd29, 12'd11,   12'd100,  12'd103},   // R2 duplicate limits
    {4'd2, 5'd29, 12'd50,   12'd100,  12'd103},
    {4'd2, 5'd29, 12'd51,   12'd100,  12'd105},
    {4'd2, 5'd29, 12'd4095, 12'd100,  12'd105},
    {4'd5, 5'd0,  12'd0,    12'd1234, 12'd1234},  // R5 non-timing
    {4'd5, 5'd3,  12'd4095, 12'd77,   12'd77},
    {4'd8, 5'd5,  12'd500,  12'd321,  12'd321},   // R8 unprogrammed
    {4'd8, 5'd30, 12'd0,    12'd4095, 12'd4095}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input int bin, input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 5'(ch); cfg_bin = 3'(bin);
    cfg_sel = sel[0]; cfg_data = 12'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input string req, input int ch, input int adc, input int tac, input int exp);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 5'(ch); in_adc = 12'(adc); in_tac = 12'(tac);
    @(negedge clk);
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "out_tac", int'(out_tac), exp);
    in_valid = 1'b0;
  endtask

  task automatic program_ch(input int ch, input int lims [8], input int offs [8]);
    for (int b = 0; b < 8; b++) begin
      cfg_write(ch, b, 0, lims[b]);
      cfg_write(ch, b, 1, offs[b] & 12'hFFF);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_ch = '0; in_adc = '0; in_tac = '0;
    cfg_we = 1'b0; cfg_ch = '0; cfg_bin = '0; cfg_sel = 1'b0; cfg_data = '0;
    repeat (4) @(negedge clk);
    check("R8", "out_valid at reset", int'(out_valid), 0);
    check("R8", "out_tac at reset", int'(out_tac), 0);
    check("R8", "out_ch at reset", int'(out_ch), 0);
    rst = 1'b0;

    // R7: channel 0 aliases the slot of channel 4; write must be dropped.
    cfg_write(0, 0, 0, 0);
    cfg_write(0, 0, 1, 100);
    apply("R7", 4, 0, 500, 500);
    apply("R7", 4, 1, 500, 500);

    program_ch(4, '{30, 60, 95, 135, 200, 300, 600, 4095},
                  '{131, 78, 45, 26, 10, -6, -24, -48});
    program_ch(29, '{10, 10, 50, 50, 4095, 4095, 4095, 4095},
                   '{1, 2, 3, 4, 5, 6, 7, 8});

    for (int i = 0; i < NV; i++) begin
      automatic string r = $sformatf("R%0d", int'(VEC[i][44:41]));
      apply(r, int'(VEC[i][40:36]), int'(VEC[i][35:24]), int'(VEC[i][23:12]), int'(VEC[i][11:0]));
    end

    // R9: idle cycle keeps the last result and drops out_valid.
    @(negedge clk);
    in_valid = 1'b0; in_ch = 5'd4; in_tac = 12'd9;
    @(negedge clk);
    check("R9", "out_valid idle", int'(out_valid), 0);
    check("R9", "out_tac held", int'(out_tac), 4095);
    check("R9", "out_ch held", int'(out_ch), 30);

    // R6: write and sample on the same edge; old offset first, new one after.
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 5'd12; cfg_bin = 3'd0; cfg_sel = 1'b1; cfg_data = 12'd7;
    in_valid = 1'b1; in_ch = 5'd12; in_adc = 12'd0; in_tac = 12'd10;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R6", "same-cycle write uses old", int'(out_tac), 10);
    @(negedge clk);
    check("R6", "next cycle uses new", int'(out_tac), 17);
    in_valid = 1'b0;

    // R3: all limits below full scale; amplitude above them uses bin 7.
    program_ch(12, '{100, 100, 100, 100, 100, 100, 100, 100},
                   '{7, 0, 0, 0, 0, 0, 0, -5});
    apply("R3", 12, 200, 50, 45);
    apply("R3", 12, 4095, 3, 0);
    apply("R2", 12, 100, 50, 57);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule